// File: doc/BRIEF.md
# Root Port Change Bitmap Generator

This block watches the per-port change flags of a hub's root ports and builds the status-change bitmap that the host reads to find out which ports need attention. A port is marked when at least one of three flags is set: connection changed, enable state changed, or over-current changed. Bit 0 of the bitmap belongs to the hub itself and is never set here. Port 0 therefore lands on bit 1, port 1 on bit 2, and so on.

The bitmap is rebuilt from the flags on every clock and registered, so each output follows its inputs by one cycle. The block reports the packed bitmap and a valid byte count. That count is the full bitmap length when any port is marked and zero otherwise. It also reports a registered "something changed" level and a one-cycle interrupt pulse when that level rises. The port count is a build-time parameter taken from the controller's capability field. The byte length is derived from it as (ports + 8) / 8 using integer division.

Top module: `port_change_bitmap`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released with all flags low, `changeMap`, `mapLen`, `anyChange` and `irqPulse` are all zero.
- R2: For each port p, from 0 to NUM_PORTS-1, bit p+1 of `changeMap` is 1 in the cycle after an edge at which any of `connChg[p]`, `enChg[p]` or `ocChg[p]` was 1. Otherwise that bit is 0.
- R3: Bit 0 of `changeMap` always reads 0.
- R4: Bits of `changeMap` above bit NUM_PORTS always read 0.
- R5: `mapLen` equals (NUM_PORTS + 8) / 8 in a cycle where `changeMap` has any bit set, and equals 0 otherwise.
- R6: `anyChange` is 1 exactly when, at the previous edge, at least one port had at least one of its three flags set.
- R7: `irqPulse` is 1 for a single cycle when `anyChange` goes from 0 to 1. It stays 0 while `anyChange` remains 1 and while `anyChange` is 0.
- R8: Each change type works on its own. A port whose only set flag is the connection, the enable or the over-current flag still produces its bitmap bit. A flag on one port never sets the bit of another port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| connChg | input | NUM_PORTS | Per-port connection-changed flags |
| enChg | input | NUM_PORTS | Per-port enable-changed flags |
| ocChg | input | NUM_PORTS | Per-port over-current-changed flags |
| changeMap | output | 8*((NUM_PORTS+8)/8) | Registered change bitmap; bit p+1 stands for port p, bit 0 is the hub |
| mapLen | output | clog2((NUM_PORTS+8)/8+1) | Valid byte count: full length when any bit is set, else 0 |
| anyChange | output | 1 | Registered flag: some port reported a change |
| irqPulse | output | 1 | One-cycle pulse on the rising edge of anyChange |

## Verification
The per-port bitmap properties compare each bit with the flags at the previous edge. They are armed only from the second edge after reset is released, so they take nothing for granted about flag values during reset. The pulse property assumes `anyChange` is zero while reset is held, which the reset logic guarantees. The stimulus still keeps all flags low during reset so the reset-state checks see a quiet block. Random flag patterns are drawn sparse, with whole vectors often zeroed. This yields runs of idle cycles, so `anyChange` rises many times and the pulse is exercised repeatedly rather than once.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // Strobes handed from the control module to the datapath each cycle.
  typedef struct packed {
    logic anyNow;   // at least one port has a change this cycle
    logic riseNow;  // anyNow is set while the registered level is still clear
  } mapStrobe_t;

  // Number of bitmap bytes for a given port count; bit 0 is the hub.
  function automatic int mapBytes(input int numPorts);
    return (numPorts + 8) / 8;
  endfunction

endpackage

// File: rtl/pcb_datapath.sv
module pcb_datapath
  import pcb_pkg::*;
#(
  parameter int NUM_PORTS = 10,
  localparam int BYTES    = mapBytes(NUM_PORTS),
  localparam int MAP_W    = BYTES * 8,
  localparam int LEN_W    = $clog2(BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] connChg,
  input  logic [NUM_PORTS-1:0] enChg,
  input  logic [NUM_PORTS-1:0] ocChg,
  input  mapStrobe_t           strobe,
  output logic [NUM_PORTS-1:0] hitVec,
  output logic [MAP_W-1:0]     changeMap,
  output logic [LEN_W-1:0]     mapLen,
  output logic                 irqPulse
);

  logic [MAP_W-1:0] nextMap;

  // One merge cell per port: any of the three change kinds marks the port.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign hitVec[p] = connChg[p] | enChg[p] | ocChg[p];
  end

  // Clear everything, then place port bits starting at position 1.
  always_comb begin
    nextMap = '0;
    nextMap[NUM_PORTS:1] = hitVec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      changeMap <= '0;
      mapLen    <= '0;
      irqPulse  <= 1'b0;
    end else begin
      changeMap <= nextMap;
      mapLen    <= strobe.anyNow ? LEN_W'(BYTES) : '0;
      irqPulse  <= strobe.riseNow;
    end
  end

endmodule

// File: rtl/pcb_control.sv
module pcb_control
  import pcb_pkg::*;
#(
  parameter int NUM_PORTS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] hitVec,
  output mapStrobe_t           strobe,
  output logic                 anyChange
);

  logic anyQ;

  always_comb begin
    strobe.anyNow  = |hitVec;
    strobe.riseNow = strobe.anyNow & ~anyQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) anyQ <= 1'b0;
    else        anyQ <= strobe.anyNow;
  end

  assign anyChange = anyQ;

endmodule

// File: rtl/port_change_bitmap.sv
module port_change_bitmap
  import pcb_pkg::*;
#(
  parameter int NUM_PORTS = 10,
  localparam int BYTES    = mapBytes(NUM_PORTS),
  localparam int MAP_W    = BYTES * 8,
  localparam int LEN_W    = $clog2(BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] connChg,
  input  logic [NUM_PORTS-1:0] enChg,
  input  logic [NUM_PORTS-1:0] ocChg,
  output logic [MAP_W-1:0]     changeMap,
  output logic [LEN_W-1:0]     mapLen,
  output logic                 anyChange,
  output logic                 irqPulse
);

  mapStrobe_t           strobe;
  logic [NUM_PORTS-1:0] hitVec;

  pcb_datapath #(.NUM_PORTS(NUM_PORTS)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .connChg   (connChg),
    .enChg     (enChg),
    .ocChg     (ocChg),
    .strobe    (strobe),
    .hitVec    (hitVec),
    .changeMap (changeMap),
    .mapLen    (mapLen),
    .irqPulse  (irqPulse)
  );

  pcb_control #(.NUM_PORTS(NUM_PORTS)) ctl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hitVec    (hitVec),
    .strobe    (strobe),
    .anyChange (anyChange)
  );

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
  import pcb_pkg::*;
#(
  parameter int NUM_PORTS = 10,
  localparam int BYTES    = mapBytes(NUM_PORTS),
  localparam int MAP_W    = BYTES * 8,
  localparam int LEN_W    = $clog2(BYTES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] connChg,
  input logic [NUM_PORTS-1:0] enChg,
  input logic [NUM_PORTS-1:0] ocChg,
  input logic [MAP_W-1:0]     changeMap,
  input logic [LEN_W-1:0]     mapLen,
  input logic                 anyChange,
  input logic                 irqPulse
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (changeMap == '0 && mapLen == '0 && !anyChange && !irqPulse));

  // R3
  bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    changeMap[0] == 1'b0);

  if (MAP_W > NUM_PORTS + 1) begin : g_pad
    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      changeMap[MAP_W-1:NUM_PORTS+1] == '0);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bit
    // R2
    port_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> changeMap[p+1] == $past(connChg[p] | enChg[p] | ocChg[p]));
  end

  // R5
  len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (changeMap != '0) |-> mapLen == LEN_W'(BYTES));

  // R5
  len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (changeMap == '0) |-> mapLen == '0);

  // R6
  any_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> anyChange == $past(|{connChg, enChg, ocChg}));

  // R7
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> (anyChange && !$past(anyChange)));

  // R7
  irq_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(anyChange) |-> irqPulse);

endmodule

bind port_change_bitmap pcb_checker #(.NUM_PORTS(NUM_PORTS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .connChg   (connChg),
  .enChg     (enChg),
  .ocChg     (ocChg),
  .changeMap (changeMap),
  .mapLen    (mapLen),
  .anyChange (anyChange),
  .irqPulse  (irqPulse)
);

// File: tb/port_change_bitmap_tb_top.sv
module port_change_bitmap_tb_top;

  localparam int NP    = 10;
  localparam int BYTES = (NP + 8) / 8;
  localparam int MW    = BYTES * 8;
  localparam int LW    = $clog2(BYTES + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] connChg, enChg, ocChg;
  logic [MW-1:0] changeMap;
  logic [LW-1:0] mapLen;
  logic          anyChange, irqPulse;

  int  checks   = 0;
  int  failures = 0;
  bit  prevAny  = 1'b0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  port_change_bitmap #(.NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .connChg(connChg), .enChg(enChg), .ocChg(ocChg),
    .changeMap(changeMap), .mapLen(mapLen), .anyChange(anyChange), .irqPulse(irqPulse)
  );

  function automatic logic [MW-1:0] expMap(logic [NP-1:0] c, logic [NP-1:0] e, logic [NP-1:0] o);
    logic [MW-1:0] m = '0;
    for (int i = 0; i < NP; i++) m[i+1] = c[i] | e[i] | o[i];
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, wait one full cycle, then compare.
  task automatic step(string req, logic [NP-1:0] c, logic [NP-1:0] e, logic [NP-1:0] o);
    logic [MW-1:0] em;
    bit            ea;
    connChg = c; enChg = e; ocChg = o;
    em = expMap(c, e, o);
    ea = (em != '0);
    @(negedge clk);
    chk({req, " R2 map"}, 64'(changeMap), 64'(em));
    chk("R3 bit0", 64'(changeMap[0]), 64'd0);
    chk("R4 pad", 64'(changeMap >> (NP + 1)), 64'd0);
    chk("R5 len", 64'(mapLen), ea ? 64'(BYTES) : 64'd0);
    chk("R6 any", 64'(anyChange), 64'(ea));
    chk("R7 irq", 64'(irqPulse), 64'(ea && !prevAny));
    prevAny = ea;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; connChg = '0; enChg = '0; ocChg = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 map", 64'(changeMap), 64'd0);
    chk("R1 len", 64'(mapLen), 64'd0);
    chk("R1 any", 64'(anyChange), 64'd0);
    chk("R1 irq", 64'(irqPulse), 64'd0);
    rst_n = 1'b1;
    step("R1 idle", '0, '0, '0);

    // R8 each change type alone, first and last port
    step("R8 conn p0", NP'(1), '0, '0);
    step("R8 en p0",   '0, NP'(1), '0);   // sustained: no second pulse (R7)
    step("R8 oc last", '0, '0, NP'(1) << (NP - 1));
    step("R7 idle", '0, '0, '0);
    step("R8 en last", '0, NP'(1) << (NP - 1), '0);
    step("R7 idle", '0, '0, '0);
    step("R2 all",  '1, '1, '1);
    step("R2 mixed", NP'(10'b0000000101), NP'(10'b0000100000), NP'(10'b1000000000));
    step("R7 idle", '0, '0, '0);
    step("R7 idle", '0, '0, '0);

    for (int n = 0; n < 400; n++) begin
      logic [NP-1:0] c, e, o;
      c = NP'($urandom) & NP'($urandom) & NP'($urandom);
      e = NP'($urandom) & NP'($urandom) & NP'($urandom);
      o = NP'($urandom) & NP'($urandom) & NP'($urandom);
      if ($urandom % 3 == 0) begin c = '0; e = '0; o = '0; end
      step("rand", c, e, o);
    end

    // R1 reset reasserted mid-run clears everything
    connChg = '1; enChg = '0; ocChg = '0;
    @(negedge clk);
    rst_n = 1'b0; connChg = '0;
    @(negedge clk);
    chk("R1 rerst map", 64'(changeMap), 64'd0);
    chk("R1 rerst any", 64'(anyChange), 64'd0);
    rst_n = 1'b1; prevAny = 1'b0;
    step("R7 after reset", NP'(2), '0, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule